// File: doc/BRIEF.md
# Mixed-Length Instruction Parcel Unpacker

This block sits between an instruction fetch stage and a decoder. It receives 60-bit instruction words through a valid/ready handshake. Each word is cut into four 15-bit parcels. An instruction occupies either one parcel (short form) or two adjacent parcels (long form). The block emits one instruction per output handshake. Each output carries the 6-bit opcode, the register fields, an 18-bit constant for long forms, and a flag that gives the length. The length of an instruction follows from its opcode alone, through a fixed lookup rule inside the block.

A small state machine controls the block through three states. `ST_EMPTY` holds no word. `ST_ISSUE` holds a word and presents the instruction at the current parcel. `ST_FAULT` is a one-cycle state that reports a long opcode found in the final parcel.

The state transitions are:
- `ST_EMPTY` to `ST_ISSUE` when a word is accepted. Issue starts at parcel 0.
- `ST_ISSUE` to itself when an instruction is taken and parcels remain. The state also holds while the output is stalled.
- `ST_ISSUE` to `ST_EMPTY` when the last instruction of the word is taken, or when `flush` is raised.
- `ST_ISSUE` to `ST_FAULT` when the current parcel is the last one and carries a long opcode.
- `ST_FAULT` to `ST_EMPTY` always.

A taken branch is signalled on `flush`. It discards whatever parcels of the held word are still unissued.

Top module: `upk_unpacker`

## Requirements
- R1: Parcels are issued from the most significant end: parcel p is bits [59-15p -: 15]. A short instruction's bits [14:9] are `out_op`, [8:6] `out_ri`, [5:3] `out_rj` and [2:0] `out_rk`, with `out_long` = 0.
- R2: A long instruction spans two adjacent parcels, 30 bits. Bits [29:24] are `out_op`, [23:21] `out_ri`, [20:18] `out_rj` and [17:0] `out_konst`, with `out_long` = 1.
- R3: An opcode is long exactly when its upper three bits are 3'o5 or 3'o6 (octal 50 to 67). Every other opcode is short.
- R4: Each output handshake advances the parcel position by 1 for a short instruction and by 2 for a long one. A word holds at most four instructions. The word is released, and the next one requested, once its last parcel has been issued.
- R5: A long opcode in the last parcel is never presented on the output. `pack_err` is then high for exactly one cycle, the parcel is dropped, and the block then requests the next word.
- R6: `flush` while a word is held discards its remaining parcels. In the following cycle `in_ready` is 1 and `out_valid` is 0, and the next word starts at parcel 0.
- R7: While `out_valid` is 1 and `out_ready` is 0 (without `flush`), `out_valid` and all instruction fields stay unchanged.
- R8: `in_ready` is 1 only while no word is held, and never together with `out_valid`. After reset, `in_ready` = 1, `out_valid` = 0 and `pack_err` = 0.
- R9: Fields a form does not carry read as zero: `out_konst` for short forms and `out_rk` for long forms.
- R10: `flush` while no word is held has no effect. A word offered in that same cycle is accepted and issued from parcel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_word | input | 60 | Instruction word from fetch |
| in_valid | input | 1 | Fetch offers `in_word` |
| in_ready | output | 1 | Block can take a word |
| flush | input | 1 | Branch taken: discard rest of held word |
| out_valid | output | 1 | An instruction is presented |
| out_ready | input | 1 | Decoder takes the instruction |
| out_op | output | 6 | Opcode |
| out_ri | output | 3 | First register field |
| out_rj | output | 3 | Second register field |
| out_rk | output | 3 | Third register field (short form only) |
| out_konst | output | 18 | Constant (long form only) |
| out_long | output | 1 | 1 for a 30-bit instruction |
| pack_err | output | 1 | One-cycle pulse: long opcode in last parcel |

## Verification
The unpacker is tried with every arrangement of short and long instructions that fills a word: SSSS, SSL, SLS, LSS and LL. These arrangements separate the cases that advance the parcel position by 1 or by 2 at each position. The three arrangements that leave a long opcode in the final parcel (SSS+L, SL+L, LS+L) show that the error is reported and the stray parcel is dropped. A sweep of all 64 opcodes in the first parcel tells the long opcodes apart from the short ones. Stalled outputs, a flush in the middle of a word, and a flush with no word held show that stalling, discarding and idle flushes each behave as required.

// File: rtl/upk_pkg.sv
package upk_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_ISSUE = 2'd1,
        ST_FAULT = 2'd2
    } upk_state_e;

    // Long-form rule (R3): the top octal digit of the opcode is 5 or 6.
    function automatic logic op_is_long(input int unsigned code, input int unsigned op_w);
        int unsigned top;
        top = (code >> (op_w - 3)) & 7;
        return (top == 5) || (top == 6);
    endfunction

endpackage

// File: rtl/upk_len_table.sv
module upk_len_table
    import upk_pkg::*;
#(
    parameter int OP_W = 6
) (
    input  logic [OP_W-1:0] op,
    output logic            is_long
);
    localparam int N_OPS = 1 << OP_W;

    logic [N_OPS-1:0] long_mask;

    for (genvar g = 0; g < N_OPS; g++) begin : g_mask
        assign long_mask[g] = op_is_long(g, OP_W);
    end

    assign is_long = long_mask[op];
endmodule

// File: rtl/upk_window.sv
module upk_window #(
    parameter int WORD_W   = 60,
    parameter int PARCEL_W = 15,
    parameter int POS_W    = 2
) (
    input  logic [WORD_W-1:0]     word,
    input  logic [POS_W-1:0]      pos,
    output logic [2*PARCEL_W-1:0] win
);
    localparam int WIN_W = 2 * PARCEL_W;

    logic [WORD_W-1:0] aligned;

    // Bring the current parcel to the top of the word; the next parcel follows it.
    assign aligned = word << (PARCEL_W * pos);
    assign win     = aligned[WORD_W-1 -: WIN_W];
endmodule

// File: rtl/upk_fields.sv
module upk_fields #(
    parameter int PARCEL_W = 15,
    parameter int OP_W     = 6,
    parameter int REG_W    = 3,
    parameter int KONST_W  = 18
) (
    input  logic [2*PARCEL_W-1:0] win,
    input  logic                  is_long,
    output logic [OP_W-1:0]       op,
    output logic [REG_W-1:0]      ri,
    output logic [REG_W-1:0]      rj,
    output logic [REG_W-1:0]      rk,
    output logic [KONST_W-1:0]    konst
);
    localparam int WIN_W = 2 * PARCEL_W;
    localparam int RI_HI = WIN_W - 1 - OP_W;
    localparam int RJ_HI = RI_HI - REG_W;
    localparam int RK_HI = RJ_HI - REG_W;

    assign op = win[WIN_W-1 -: OP_W];
    assign ri = win[RI_HI -: REG_W];
    assign rj = win[RJ_HI -: REG_W];

    // The third register field and the constant overlap; only one is live per form.
    always_comb begin
        if (is_long) begin
            rk    = '0;
            konst = win[KONST_W-1:0];
        end else begin
            rk    = win[RK_HI -: REG_W];
            konst = '0;
        end
    end
endmodule

// File: rtl/upk_unpacker.sv
module upk_unpacker
    import upk_pkg::*;
#(
    parameter  int WORD_W   = 60,
    parameter  int PARCEL_W = 15,
    parameter  int OP_W     = 6,
    parameter  int REG_W    = 3,
    localparam int KONST_W  = 2 * PARCEL_W - OP_W - 2 * REG_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [WORD_W-1:0]  in_word,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic               flush,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [OP_W-1:0]    out_op,
    output logic [REG_W-1:0]   out_ri,
    output logic [REG_W-1:0]   out_rj,
    output logic [REG_W-1:0]   out_rk,
    output logic [KONST_W-1:0] out_konst,
    output logic               out_long,
    output logic               pack_err
);
    localparam int NPARCEL = WORD_W / PARCEL_W;
    localparam int POS_W   = $clog2(NPARCEL);
    localparam int CNT_W   = POS_W + 1;
    localparam int WIN_W   = 2 * PARCEL_W;

    upk_state_e        state_q, state_d;
    logic [POS_W-1:0]  pos_q, pos_d;
    logic [WORD_W-1:0] word_q;
    logic [WIN_W-1:0]  win;
    logic              cur_long;
    logic [CNT_W-1:0]  pos_next;
    logic              split_long;

    upk_window #(
        .WORD_W  (WORD_W),
        .PARCEL_W(PARCEL_W),
        .POS_W   (POS_W)
    ) u_window (
        .word(word_q),
        .pos (pos_q),
        .win (win)
    );

    upk_len_table #(
        .OP_W(OP_W)
    ) u_len (
        .op     (win[WIN_W-1 -: OP_W]),
        .is_long(cur_long)
    );

    upk_fields #(
        .PARCEL_W(PARCEL_W),
        .OP_W    (OP_W),
        .REG_W   (REG_W),
        .KONST_W (KONST_W)
    ) u_fields (
        .win    (win),
        .is_long(cur_long),
        .op     (out_op),
        .ri     (out_ri),
        .rj     (out_rj),
        .rk     (out_rk),
        .konst  (out_konst)
    );

    assign out_long   = cur_long;
    assign pos_next   = {1'b0, pos_q} + (cur_long ? CNT_W'(2) : CNT_W'(1));
    assign split_long = cur_long && (pos_next > CNT_W'(NPARCEL));

    // Next state and parcel position
    always_comb begin
        state_d = state_q;
        pos_d   = pos_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (in_valid) begin
                    state_d = ST_ISSUE;
                    pos_d   = '0;
                end
            end
            ST_ISSUE: begin
                if (flush) begin
                    state_d = ST_EMPTY;
                end else if (split_long) begin
                    state_d = ST_FAULT;
                end else if (out_ready) begin
                    if (pos_next >= CNT_W'(NPARCEL)) begin
                        state_d = ST_EMPTY;
                    end else begin
                        pos_d = pos_next[POS_W-1:0];
                    end
                end
            end
            ST_FAULT: begin
                state_d = ST_EMPTY;
            end
            default: begin
                state_d = ST_EMPTY;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            pos_q   <= '0;
        end else begin
            state_q <= state_d;
            pos_q   <= pos_d;
        end
    end

    // Held word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (state_q == ST_EMPTY && in_valid) begin
            word_q <= in_word;
        end
    end

    // Handshake and status outputs
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        pack_err  = 1'b0;
        unique case (state_q)
            ST_EMPTY: in_ready  = 1'b1;
            ST_ISSUE: out_valid = !split_long;
            ST_FAULT: pack_err  = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/upk_unpacker_chk.sv
module upk_unpacker_chk #(
    parameter int OP_W    = 6,
    parameter int REG_W   = 3,
    parameter int KONST_W = 18
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               in_ready,
    input logic               flush,
    input logic               out_valid,
    input logic               out_ready,
    input logic [OP_W-1:0]    out_op,
    input logic [REG_W-1:0]   out_ri,
    input logic [REG_W-1:0]   out_rj,
    input logic [REG_W-1:0]   out_rk,
    input logic [KONST_W-1:0] out_konst,
    input logic               out_long,
    input logic               pack_err
);
    assert_err_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pack_err |=> !pack_err);

    assert_err_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pack_err |-> (!out_valid && !in_ready));

    assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !flush) |=>
            (out_valid && $stable(out_op) && $stable(out_ri) && $stable(out_rj)
             && $stable(out_rk) && $stable(out_konst) && $stable(out_long)));

    assert_busy_no_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    assert_load_closes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    assert_flush_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && !in_ready) |=> (in_ready && !out_valid));

    assert_short_no_konst_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_long) |-> (out_konst == '0));

    assert_long_no_rk_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_long) |-> (out_rk == '0));
endmodule

bind upk_unpacker upk_unpacker_chk #(
    .OP_W   (OP_W),
    .REG_W  (REG_W),
    .KONST_W(KONST_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .flush    (flush),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_op   (out_op),
    .out_ri   (out_ri),
    .out_rj   (out_rj),
    .out_rk   (out_rk),
    .out_konst(out_konst),
    .out_long (out_long),
    .pack_err (pack_err)
);

// File: tb/upk_unpacker_tb.sv
module upk_unpacker_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [59:0] in_word;
    logic        in_valid;
    logic        in_ready;
    logic        flush;
    logic        out_valid;
    logic        out_ready;
    logic [5:0]  out_op;
    logic [2:0]  out_ri, out_rj, out_rk;
    logic [17:0] out_konst;
    logic        out_long;
    logic        pack_err;

    always #5 clk = ~clk;

    upk_unpacker u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_word  (in_word),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .flush    (flush),
        .out_valid(out_valid),
        .out_ready(out_ready),
        .out_op   (out_op),
        .out_ri   (out_ri),
        .out_rj   (out_rj),
        .out_rk   (out_rk),
        .out_konst(out_konst),
        .out_long (out_long),
        .pack_err (pack_err)
    );

    int checks = 0;
    int errors = 0;

    // Expected instruction stream for the current word
    logic [5:0]  exp_op [4];
    logic [2:0]  exp_ri [4];
    logic [2:0]  exp_rj [4];
    logic [2:0]  exp_rk [4];
    logic [17:0] exp_k  [4];
    logic        exp_l  [4];
    int          exp_n;
    logic        exp_err;
    logic [31:0] seed = 32'h1234_5678;

    // Vector table: {2-bit code per slot (1 short, 2 long, 3 long in last parcel), stall cycles}
    localparam logic [11:0] VEC [10] = '{
        {8'b01_01_01_01, 4'd0},
        {8'b01_01_10_00, 4'd0},
        {8'b01_10_01_00, 4'd2},
        {8'b10_01_01_00, 4'd0},
        {8'b10_10_00_00, 4'd1},
        {8'b01_01_01_11, 4'd0},
        {8'b10_01_11_00, 4'd0},
        {8'b01_10_11_00, 4'd1},
        {8'b01_01_01_01, 4'd3},
        {8'b10_10_00_00, 4'd0}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic rnd(output logic [31:0] r);
        seed = seed * 32'd1664525 + 32'd1013904223;
        r = seed;
    endtask

    function automatic logic [5:0] short_op(input logic [31:0] r);
        logic [2:0] top;
        case (r[10:8] % 3'd6)
            3'd0:    top = 3'd0;
            3'd1:    top = 3'd1;
            3'd2:    top = 3'd2;
            3'd3:    top = 3'd3;
            3'd4:    top = 3'd4;
            default: top = 3'd7;
        endcase
        return {top, r[13:11]};
    endfunction

    function automatic logic [5:0] long_op(input logic [31:0] r);
        return {(r[8] ? 3'd6 : 3'd5), r[13:11]};
    endfunction

    function automatic logic long_rule(input logic [5:0] op);
        return (op[5:3] == 3'd5) || (op[5:3] == 3'd6);
    endfunction

    task automatic make_word(input logic [7:0] pat, input int first_op, output logic [59:0] w);
        int          pos;
        logic [31:0] r;
        logic [5:0]  op;
        logic [1:0]  code;
        w = '0; exp_n = 0; exp_err = 1'b0; pos = 0;
        for (int s = 0; s < 4; s++) begin
            code = pat[7-2*s -: 2];
            if (code != 2'd0 && pos < 4) begin
                rnd(r);
                op = (code == 2'd1) ? short_op(r) : long_op(r);
                if (s == 0 && first_op >= 0) op = 6'(first_op);
                if (code == 2'd3) begin
                    w[59-15*pos -: 15] = {op, r[20:12]};
                    exp_err = 1'b1;
                    pos = pos + 1;
                end else if (code == 2'd2) begin
                    w[59-15*pos -: 30] = {op, r[30:28], r[27:25], r[17:0]};
                    exp_op[exp_n] = op; exp_ri[exp_n] = r[30:28]; exp_rj[exp_n] = r[27:25];
                    exp_rk[exp_n] = 3'd0; exp_k[exp_n] = r[17:0]; exp_l[exp_n] = 1'b1;
                    exp_n = exp_n + 1;
                    pos = pos + 2;
                end else begin
                    w[59-15*pos -: 15] = {op, r[30:28], r[27:25], r[24:22]};
                    exp_op[exp_n] = op; exp_ri[exp_n] = r[30:28]; exp_rj[exp_n] = r[27:25];
                    exp_rk[exp_n] = r[24:22]; exp_k[exp_n] = 18'd0; exp_l[exp_n] = 1'b0;
                    exp_n = exp_n + 1;
                    pos = pos + 1;
                end
            end
        end
    endtask

    // Called at a negedge with the block empty; returns at the negedge after the load.
    task automatic load(input logic [59:0] w);
        in_word = w;
        in_valid = 1'b1;
        chk("R8 in_ready before load", in_ready, 1);
        @(posedge clk); @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic drain(input int stall);
        string tg;
        for (int n = 0; n < exp_n; n++) begin
            tg = exp_l[n] ? "R2" : "R1";
            for (int s = 0; s < ((n == 0) ? stall : 0); s++) begin
                chk("R7 stalled valid", out_valid, 1);
                chk("R7 stalled op", out_op, exp_op[n]);
                chk("R7 stalled konst", out_konst, exp_k[n]);
                @(posedge clk); @(negedge clk);
            end
            chk("R4 valid at instruction", out_valid, 1);
            chk({tg, " op"}, out_op, exp_op[n]);
            chk({tg, " ri"}, out_ri, exp_ri[n]);
            chk({tg, " rj"}, out_rj, exp_rj[n]);
            chk({tg, " rk"}, out_rk, exp_rk[n]);
            chk({tg, " konst"}, out_konst, exp_k[n]);
            chk({tg, " long flag"}, out_long, exp_l[n]);
            chk("R8 no in_ready while issuing", in_ready, 0);
            out_ready = 1'b1;
            @(posedge clk); @(negedge clk);
            out_ready = 1'b0;
        end
        if (exp_err) begin
            chk("R5 bad parcel not presented", out_valid, 0);
            chk("R5 no early pulse", pack_err, 0);
            @(posedge clk); @(negedge clk);
            chk("R5 error pulse", pack_err, 1);
            chk("R5 busy during pulse", in_ready, 0);
            @(posedge clk); @(negedge clk);
            chk("R5 pulse ends", pack_err, 0);
            chk("R5 next word requested", in_ready, 1);
        end else begin
            chk("R4 word released", in_ready, 1);
            chk("R4 no stray output", out_valid, 0);
        end
    endtask

    initial begin
        logic [59:0] w;
        rst_n = 1'b0; in_word = '0; in_valid = 1'b0; flush = 1'b0; out_ready = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R8 reset in_ready", in_ready, 1);
        chk("R8 reset out_valid", out_valid, 0);
        chk("R8 reset pack_err", pack_err, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: every length arrangement in one word
        for (int v = 0; v < 10; v++) begin
            make_word(VEC[v][11:4], -1, w);
            load(w);
            drain(int'(VEC[v][3:0]));
        end

        // R3: opcode sweep in parcel 0
        for (int op = 0; op < 64; op++) begin
            logic lng;
            lng = long_rule(6'(op));
            make_word(lng ? 8'b10_01_01_00 : 8'b01_01_01_01, op, w);
            load(w);
            chk("R3 length of opcode", out_long, lng);
            drain(0);
        end

        // R6: flush after the first instruction
        make_word(8'b01_01_01_01, -1, w);
        load(w);
        out_ready = 1'b1;
        @(posedge clk); @(negedge clk);
        out_ready = 1'b0;
        chk("R6 second parcel pending", out_valid, 1);
        flush = 1'b1;
        @(posedge clk); @(negedge clk);
        flush = 1'b0;
        chk("R6 in_ready after flush", in_ready, 1);
        chk("R6 no output after flush", out_valid, 0);
        make_word(8'b10_01_01_00, -1, w);
        load(w);
        chk("R6 restarts at parcel 0", out_op, exp_op[0]);
        drain(0);

        // R10: flush with nothing held, then flush together with a new word
        flush = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R10 idle flush keeps in_ready", in_ready, 1);
        chk("R10 idle flush no output", out_valid, 0);
        chk("R10 idle flush no error", pack_err, 0);
        make_word(8'b01_10_01_00, -1, w);
        load(w);
        flush = 1'b0;
        chk("R10 word accepted during flush", out_valid, 1);
        chk("R10 first parcel op", out_op, exp_op[0]);
        drain(0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule